// File: doc/BRIEF.md
# Periodic tick timer with interrupt tally

This block is a periodic tick timer. A counter advances by one on every cycle where the external tick strobe is high and the run bit is set. It is compared against a programmable compare value. When a tick finds the counter equal to the compare value, the timer raises a one-cycle interrupt request. Optionally, it also returns the counter to zero, which gives a fixed-period tick.

A small 4-bit tally counts the interrupts issued so that software can spot missed ticks. Writing one to a clear bit empties the tally. Software reaches the counter, the compare value and a control/status byte through a plain synchronous register port. Writes take effect on the clock edge, and read data follows the address combinationally.

Register map:

| Address | Register |
|---|---|
| 0 | counter |
| 1 | compare |
| 2 | control/status |
| 3 | reads zero |

Control byte layout:

| Bits | Field | Access |
|---|---|---|
| [7:4] | tally | read-only |
| 3 | tally-clear strobe | write 1 to clear, reads 0 |
| 2 | zero-on-match | read/write |
| 1 | run | read/write |
| 0 and above 7 | unused | read 0 |

Top module: `tick_tally_timer`

## Requirements
- R1: After reset, the counter, compare, control (run, zero-on-match, tally) and irq_o are all 0.
- R2: The counter (address 0) rises by exactly one on each clock edge where tick_en_i is 1 and run (control bit 1) is 1. In all other cycles it holds its value, unless it is written.
- R3: With zero-on-match (control bit 2) at 1, a tick with run=1 that finds counter == compare loads the counter with 0.
- R4: With zero-on-match at 0, the counter keeps incrementing through the match value to compare+1, and wraps modulo 2^32.
- R5: irq_o is high for exactly the one clock cycle following an edge on which tick_en_i=1, run=1 and counter == compare, whatever the zero-on-match setting. At all other times it is low.
- R6: The tally (control bits 7:4) increments by one for every interrupt issued and wraps from 15 to 0.
- R7: A control write with bit 3 set clears the tally. This clear wins over an increment in the same cycle. Bit 3 always reads back 0.
- R8: Control reads return the tally in bits 7:4, zero-on-match in bit 2 and run in bit 1. Bits 0 and 3, and all bits above 7, read 0. A write to bit 0 has no effect.
- R9: The counter (address 0) and compare (address 1) read back the last written value. A counter write wins over a same-cycle increment or zero-on-match. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_en_i | input | 1 | Tick strobe that advances the counter (e.g. a prescaler output) |
| bus_addr_i | input | 2 | Register select |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe, sampled on the clock edge |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | One-cycle interrupt request on compare match |

## Verification
The bench goes after cycles where two events collide, because each collision has a plausible wrong winner:
- A counter write landing on a matching tick: a design that lets the increment or zero-on-match win loses the written value.
- A tally clear landing on an interrupt: a design that lets the increment win leaves a tally of 1 instead of 0.
- Sixteen back-to-back matches with compare 0 and zero-on-match set: this exposes a tally that saturates instead of wrapping, and a match that is reported only once.
- Ticks with run low, and match values sitting in the counter during non-tick cycles: these catch a counter that free-runs, or an interrupt raised without a tick.
- Long random runs with small compare values: these compare every read and every irq_o cycle against a reference model.

// File: rtl/tick_tally_pkg.sv
package tick_tally_pkg;

   typedef enum logic [1:0] {
      SEL_COUNT   = 2'd0,
      SEL_COMPARE = 2'd1,
      SEL_CTRL    = 2'd2,
      SEL_NONE    = 2'd3
   } reg_sel_e;

   localparam int CTRL_RUN_BIT   = 1;
   localparam int CTRL_ZERO_BIT  = 2;
   localparam int CTRL_CLR_BIT   = 3;
   localparam int CTRL_TALLY_LSB = 4;

endpackage

// File: rtl/tt_regs.sv
module tt_regs
   import tick_tally_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 32,
   parameter int TALLY_W = 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [1:0]         addr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic               we_i,
   input  logic [CNT_W-1:0]   cnt_i,
   input  logic [TALLY_W-1:0] tally_i,
   output logic               cnt_we_o,
   output logic [CNT_W-1:0]   cnt_wdata_o,
   output logic [CNT_W-1:0]   cmp_o,
   output logic               run_o,
   output logic               zero_o,
   output logic               tally_clr_o,
   output logic [DATA_W-1:0]  rdata_o
);

   localparam int CTRL_TOP = CTRL_TALLY_LSB + TALLY_W;

   if (CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("tt_regs: CNT_W must not exceed DATA_W");
   end
   if (CTRL_TOP > DATA_W) begin : g_bad_tally_w
      $error("tt_regs: tally field does not fit the data word");
   end

   reg_sel_e sel;
   logic     ctrl_we;
   logic     cmp_we;

   assign sel         = reg_sel_e'(addr_i);
   assign cnt_we_o    = we_i && (sel == SEL_COUNT);
   assign cmp_we      = we_i && (sel == SEL_COMPARE);
   assign ctrl_we     = we_i && (sel == SEL_CTRL);
   assign cnt_wdata_o = wdata_i[CNT_W-1:0];
   assign tally_clr_o = ctrl_we && wdata_i[CTRL_CLR_BIT];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cmp_o  <= '0;
         run_o  <= 1'b0;
         zero_o <= 1'b0;
      end else begin
         if (cmp_we) begin
            cmp_o <= wdata_i[CNT_W-1:0];
         end
         if (ctrl_we) begin
            run_o  <= wdata_i[CTRL_RUN_BIT];
            zero_o <= wdata_i[CTRL_ZERO_BIT];
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (sel)
         SEL_COUNT:   rdata_o[CNT_W-1:0] = cnt_i;
         SEL_COMPARE: rdata_o[CNT_W-1:0] = cmp_o;
         SEL_CTRL: begin
            rdata_o[CTRL_TALLY_LSB +: TALLY_W] = tally_i;
            rdata_o[CTRL_ZERO_BIT]             = zero_o;
            rdata_o[CTRL_RUN_BIT]              = run_o;
         end
         default:     rdata_o = '0;
      endcase
   end

   // R9: compare holds the written value
   a_r9_cmp_write : assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_we |=> (cmp_o == $past(wdata_i[CNT_W-1:0])));

   // R8: control bit 3 never reads as one
   a_r8_clr_reads_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel == SEL_CTRL) |-> !rdata_o[CTRL_CLR_BIT] && !rdata_o[0]);

endmodule

// File: rtl/tt_count.sv
module tt_count #(
   parameter int CNT_W   = 32,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             run_i,
   input  logic             zero_i,
   input  logic             wr_en_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic [CNT_W-1:0] cmp_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             match_o,
   output logic             irq_o
);

   if (CNT_W < 2) begin : g_bad_w
      $error("tt_count: CNT_W must be at least 2");
   end

   logic advance;

   assign advance = run_i && tick_i;
   assign match_o = advance && (cnt_o == cmp_i);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_o <= '0;
      end else if (wr_en_i) begin
         cnt_o <= wr_data_i;
      end else if (advance) begin
         cnt_o <= (match_o && zero_i) ? '0 : cnt_o + 1'b1;
      end
   end

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni) irq_q <= 1'b0;
         else         irq_q <= match_o;
      end
      assign irq_o = irq_q;

      // R5: one pulse per match, none otherwise
      a_r5_irq_follows_match : assert property (@(posedge clk_i) disable iff (!rst_ni)
         match_o |=> irq_o);
      a_r5_irq_quiet : assert property (@(posedge clk_i) disable iff (!rst_ni)
         !match_o |=> !irq_o);
   end else begin : g_irq_comb
      assign irq_o = match_o;
   end

   // R2: no tick or not running means the counter holds
   a_r2_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!advance && !wr_en_i) |=> $stable(cnt_o));

   // R3: zero-on-match reloads zero
   a_r3_zero_on_match : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (match_o && zero_i && !wr_en_i) |=> (cnt_o == '0));

   // R4: without zero-on-match the counter keeps stepping
   a_r4_step : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (advance && !zero_i && !wr_en_i) |=> (cnt_o == $past(cnt_o) + 1'b1));

   // R9: a write wins over any count activity
   a_r9_write_wins : assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> (cnt_o == $past(wr_data_i)));

endmodule

// File: rtl/tt_tally.sv
module tt_tally #(
   parameter int TALLY_W = 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               inc_i,
   input  logic               clr_i,
   output logic [TALLY_W-1:0] tally_o
);

   if (TALLY_W < 1) begin : g_bad_w
      $error("tt_tally: TALLY_W must be at least 1");
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     tally_o <= '0;
      else if (clr_i)  tally_o <= '0;
      else if (inc_i)  tally_o <= tally_o + 1'b1;
   end

   // R6: increment and wrap
   a_r6_tally_step : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i && !clr_i) |=> (tally_o == $past(tally_o) + 1'b1));

   // R7: clear wins
   a_r7_clear_wins : assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (tally_o == '0));

   // R6: no change without an interrupt
   a_r6_tally_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inc_i && !clr_i) |=> $stable(tally_o));

endmodule

// File: rtl/tick_tally_timer.sv
module tick_tally_timer #(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 32,
   parameter int TALLY_W = 4,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_en_i,
   input  logic [1:0]        bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   input  logic              bus_we_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o
);

   logic [CNT_W-1:0]   cnt;
   logic [CNT_W-1:0]   cnt_wdata;
   logic [CNT_W-1:0]   cmp;
   logic [TALLY_W-1:0] tally;
   logic               cnt_we;
   logic               run;
   logic               zero;
   logic               tally_clr;
   logic               match;

   tt_regs #(
      .DATA_W  (DATA_W),
      .CNT_W   (CNT_W),
      .TALLY_W (TALLY_W)
   ) regs_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .addr_i      (bus_addr_i),
      .wdata_i     (bus_wdata_i),
      .we_i        (bus_we_i),
      .cnt_i       (cnt),
      .tally_i     (tally),
      .cnt_we_o    (cnt_we),
      .cnt_wdata_o (cnt_wdata),
      .cmp_o       (cmp),
      .run_o       (run),
      .zero_o      (zero),
      .tally_clr_o (tally_clr),
      .rdata_o     (bus_rdata_o)
   );

   tt_count #(
      .CNT_W   (CNT_W),
      .IRQ_REG (IRQ_REG)
   ) count_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_en_i),
      .run_i     (run),
      .zero_i    (zero),
      .wr_en_i   (cnt_we),
      .wr_data_i (cnt_wdata),
      .cmp_i     (cmp),
      .cnt_o     (cnt),
      .match_o   (match),
      .irq_o     (irq_o)
   );

   tt_tally #(
      .TALLY_W (TALLY_W)
   ) tally_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (match),
      .clr_i   (tally_clr),
      .tally_o (tally)
   );

endmodule

// File: tb/tick_tally_timer_tb.sv
module tick_tally_timer_tb_top;

   localparam time CLK_P = 20ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0;
   logic        we = 1'b0;
   logic [31:0] rdata;
   logic        irq;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   // reference model state
   logic [31:0] m_cnt = '0;
   logic [31:0] m_cmp = '0;
   logic        m_run = 1'b0;
   logic        m_zero = 1'b0;
   logic [3:0]  m_tally = '0;
   logic        m_irq = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   tick_tally_timer dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .tick_en_i   (tick),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_we_i    (we),
      .bus_rdata_o (rdata),
      .irq_o       (irq)
   );

   function automatic logic [31:0] model_read(input logic [1:0] a);
      case (a)
         2'd0:    return m_cnt;
         2'd1:    return m_cmp;
         2'd2:    return {24'd0, m_tally, 1'b0, m_zero, m_run, 1'b0};
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // one clock cycle: drive, check read data, clock, update model, check irq
   task automatic cyc(input bit tk, input logic [1:0] a, input bit w,
                      input logic [31:0] d, input string rtag);
      logic [31:0] exp_rd;
      logic        hit;
      @(negedge clk);
      tick = tk; addr = a; we = w; wdata = d;
      #5;
      exp_rd = model_read(a);
      check(rdata === exp_rd, rtag, rdata, exp_rd);
      @(posedge clk);
      hit = m_run && tk && (m_cnt == m_cmp);
      if (w && a == 2'd0)   m_cnt = d;
      else if (m_run && tk) m_cnt = (hit && m_zero) ? 32'd0 : m_cnt + 32'd1;
      if (w && a == 2'd1) m_cmp = d;
      if (w && a == 2'd2) begin
         m_run  = d[1];
         m_zero = d[2];
      end
      if (w && a == 2'd2 && d[3]) m_tally = 4'd0;
      else if (hit)               m_tally = m_tally + 4'd1;
      m_irq = hit;
      #5;
      check(irq === m_irq, "R5 irq pulse", {31'd0, irq}, {31'd0, m_irq});
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      cyc(1'b0, a, 1'b1, d, "R9 read during write");
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) cyc(1'b1, 2'd3, 1'b0, '0, "R9 idle address reads zero");
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: run did not complete");
         $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      cyc(1'b0, 2'd0, 1'b0, '0, "R1 counter after reset");
      cyc(1'b0, 2'd1, 1'b0, '0, "R1 compare after reset");
      cyc(1'b0, 2'd2, 1'b0, '0, "R1 control after reset");

      // R2: counting and holding
      wr(2'd1, 32'd1000);
      wr(2'd2, 32'h2);
      ticks(4);
      cyc(1'b0, 2'd0, 1'b0, '0, "R2 counts ticks");
      cyc(1'b0, 2'd0, 1'b0, '0, "R2 holds without tick");
      wr(2'd2, 32'h0);
      ticks(3);
      cyc(1'b0, 2'd0, 1'b0, '0, "R2 frozen when run is low");

      // R3: zero on match
      wr(2'd0, 32'd0);
      wr(2'd1, 32'd5);
      wr(2'd2, 32'h6);
      ticks(7);
      cyc(1'b0, 2'd0, 1'b0, '0, "R3 counter restarted from zero");

      // R4: run through the match
      wr(2'd2, 32'h2);
      wr(2'd0, 32'd0);
      wr(2'd1, 32'd3);
      ticks(5);
      cyc(1'b0, 2'd0, 1'b0, '0, "R4 counts past match");
      wr(2'd0, 32'hFFFF_FFFF);
      ticks(2);
      cyc(1'b0, 2'd0, 1'b0, '0, "R4 wraps modulo 2^32");

      // R6: tally wrap with a match on every tick
      wr(2'd2, 32'hE);
      wr(2'd1, 32'd0);
      wr(2'd0, 32'd0);
      ticks(17);
      cyc(1'b0, 2'd2, 1'b0, '0, "R6 tally wrapped");

      // R7: clear and increment in one cycle
      cyc(1'b1, 2'd2, 1'b1, 32'hE, "R7 write with match");
      cyc(1'b0, 2'd2, 1'b0, '0, "R7 clear wins over increment");

      // R8: bit 0 and bit 3 read zero
      ticks(3);
      wr(2'd2, 32'hFF);
      cyc(1'b0, 2'd2, 1'b0, '0, "R8 control layout");

      // R9: write beats increment
      wr(2'd1, 32'd100);
      cyc(1'b1, 2'd0, 1'b1, 32'd50, "R9 write with tick");
      cyc(1'b0, 2'd0, 1'b0, '0, "R9 counter write wins");
      cyc(1'b0, 2'd1, 1'b0, '0, "R9 compare readback");
      wr(2'd1, 32'd50);
      cyc(1'b1, 2'd0, 1'b1, 32'd7, "R9 write on matching tick");
      cyc(1'b0, 2'd0, 1'b0, '0, "R9 write wins over zero-on-match");

      // random mix
      void'($urandom(32'd1234));
      for (int i = 0; i < 4000; i++) begin
         logic [1:0]  a;
         logic [31:0] d;
         bit          w;
         bit          tk;
         a  = 2'($urandom_range(0, 3));
         w  = ($urandom_range(0, 9) == 0);
         tk = ($urandom_range(0, 2) != 0);
         case (a)
            2'd0:    d = 32'($urandom_range(0, 7));
            2'd1:    d = 32'($urandom_range(0, 7));
            2'd2:    d = {$urandom} | 32'h2;
            default: d = $urandom;
         endcase
         if (a == 2'd2 && $urandom_range(0, 3) != 0) d[3] = 1'b0;
         if (a == 2'd2)      cyc(tk, a, w, d, "R8 random control read");
         else if (a == 2'd3) cyc(tk, a, w, d, "R9 random unused read");
         else                cyc(tk, a, w, d, "R9 random counter/compare read");
      end

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule